// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home controller for one memory bank shared by a set of caching sites. For every block in its small internal memory it keeps a directory record: a state, a sharer bit vector and an owner id. It accepts shared and exclusive requests from caches. To answer them it sends invalidation, writeback and flush requests to the sharers or the owner, collects their replies, and writes returned data into memory. It then sends a shared or exclusive reply, with data, to the requesting site.

Messages enter on one valid/ready channel and leave on one registered channel that emits at most one message per cycle. An outgoing message addresses its targets through a site bit mask, so a single invalidation message can reach several sharers at once. While a block waits for acknowledgements or for owner data, a new request to that block is parked in a one-entry slot for that block. Requests to other blocks keep flowing. When the block settles, the parked request is replayed ahead of new input.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is shared with an empty sharer set, holds the data value equal to its own index, `in_ready_o` is high and `out_valid_o` is low.
- R2: A shared request (type 0) to a block in shared state returns a shared reply (type 8) with the memory data to the requester and adds the requester to the sharer set.
- R3: An exclusive request (type 1) to a shared block whose sharer set, less the requester, is empty returns an exclusive reply (type 9) with the memory data at once. The block becomes modified and owned by the requester.
- R4: An exclusive request to a shared block with other sharers sends one invalidation request (type 5) whose destination mask is the sharer set without the requester. The block then waits. Each invalidation reply (type 2) from a listed sharer removes that sharer. When the last one is removed, the requester gets an exclusive reply with the memory data and becomes the owner.
- R5: A shared request to a modified block sends a writeback request (type 6) to the owner. The owner's writeback reply (type 3) stores its data in memory. The requester then gets a shared reply with that data, and the sharer set becomes {owner, requester}.
- R6: An exclusive request to a modified block sends a flush request (type 7) to the owner. The owner's flush reply (type 4) stores its data in memory. The requester then gets an exclusive reply with that data and becomes the owner.
- R7: A request to a waiting block is accepted and parked, with no output, when that block's slot is empty. A further request to the same block holds `in_ready_o` low. Requests to other blocks are still served.
- R8: A parked request is replayed in the cycle after its block leaves the waiting state, ahead of new input, and its output follows one cycle later.
- R9: A reply that the block is not waiting for, by type or by site, produces no output and leaves the directory record unchanged.
- R10: Each accepted message yields at most one output, registered and visible after the accepting clock edge. Bit n of `out_dst_o` addresses site n, and shared and exclusive replies address exactly one site.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| in_valid_i | input | 1 | incoming message present |
| in_ready_o | output | 1 | incoming message taken this cycle |
| in_type_i | input | 4 | incoming message type code |
| in_site_i | input | IW | sending site id |
| in_blk_i | input | BW | block index |
| in_data_i | input | DW | data carried by writeback or flush replies |
| out_valid_o | output | 1 | outgoing message present |
| out_type_o | output | 4 | outgoing message type code |
| out_dst_o | output | K | destination site mask |
| out_blk_o | output | BW | block index |
| out_data_o | output | DW | data of a shared or exclusive reply |

## Verification
Shared requests are tried on untouched blocks, on blocks with several sharers and on modified blocks. This separates the direct reply from the writeback path. Exclusive requests are tried with an empty set, with the requester as sole sharer, with one other sharer and with two, so that the immediate reply can be told apart from a correctly masked invalidation. The acknowledgements are given one at a time, which shows that the reply waits for the last one. A parked request, a blocked second request and a request to another block are interleaved, which separates per-block stalling from a global stall and confirms replay order. Stray replies are followed by a request whose answer reveals whether the record changed.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;
  typedef enum logic [3:0] {
    M_SH_REQ    = 4'd0,
    M_EX_REQ    = 4'd1,
    M_INV_REP   = 4'd2,
    M_WB_REP    = 4'd3,
    M_FLUSH_REP = 4'd4,
    M_INV_REQ   = 4'd5,
    M_WB_REQ    = 4'd6,
    M_FLUSH_REQ = 4'd7,
    M_SH_REP    = 4'd8,
    M_EX_REP    = 4'd9
  } msg_e;

  typedef enum logic [1:0] {
    D_RD   = 2'd0,  // shared by sharer set, memory valid
    D_WR   = 2'd1,  // owned and modified, memory stale
    D_TRD  = 2'd2,  // collecting invalidation acks
    D_TWR  = 2'd3   // waiting for owner data
  } dstate_e;
endpackage

// File: rtl/dir_park_slots.sv
`timescale 1ns/1ps
module dir_park_slots #(
  parameter int NBLK = 4,
  parameter int IW   = 2,
  parameter int BW   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [BW-1:0]   set_blk_i,
  input  logic            set_ex_i,
  input  logic [IW-1:0]   set_site_i,
  input  logic            clr_i,
  input  logic [BW-1:0]   clr_blk_i,
  output logic [NBLK-1:0] vld_o,
  output logic [NBLK-1:0] ex_o,
  output logic [IW-1:0]   site_o [NBLK]
);
  for (genvar b = 0; b < NBLK; b++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[b]  <= 1'b0;
        ex_o[b]   <= 1'b0;
        site_o[b] <= '0;
      end else if (set_i && set_blk_i == BW'(b)) begin
        vld_o[b]  <= 1'b1;
        ex_o[b]   <= set_ex_i;
        site_o[b] <= set_site_i;
      end else if (clr_i && clr_blk_i == BW'(b)) begin
        vld_o[b]  <= 1'b0;
      end
    end

    AST_NO_DOUBLE_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o[b] |-> !(set_i && set_blk_i == BW'(b)))) else $error("double park"); // R7
  end
endmodule

// File: rtl/dir_next_state.sv
`timescale 1ns/1ps
module dir_next_state
  import dir_pkg::*;
#(
  parameter int K  = 4,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  dstate_e        st_i,
  input  logic [K-1:0]   shr_i,
  input  logic [IW-1:0]  own_i,
  input  logic [IW-1:0]  pid_i,
  input  logic           pex_i,
  input  logic [DW-1:0]  dat_i,
  input  msg_e           msg_i,
  input  logic [IW-1:0]  site_i,
  input  logic [DW-1:0]  wdat_i,
  output dstate_e        st_o,
  output logic [K-1:0]   shr_o,
  output logic [IW-1:0]  own_o,
  output logic [IW-1:0]  pid_o,
  output logic           pex_o,
  output logic [DW-1:0]  dat_o,
  output logic           ov_o,
  output msg_e           otyp_o,
  output logic [K-1:0]   odst_o,
  output logic [DW-1:0]  odat_o
);
  logic [K-1:0] site_oh, own_oh, pid_oh, others, rem;

  always_comb begin
    site_oh = K'(1) << site_i;
    own_oh  = K'(1) << own_i;
    pid_oh  = K'(1) << pid_i;
    others  = shr_i & ~site_oh;
    rem     = shr_i & ~site_oh;
    st_o    = st_i;
    shr_o   = shr_i;
    own_o   = own_i;
    pid_o   = pid_i;
    pex_o   = pex_i;
    dat_o   = dat_i;
    ov_o    = 1'b0;
    otyp_o  = M_SH_REP;
    odst_o  = '0;
    odat_o  = dat_i;
    unique case (st_i)
      D_RD: begin
        if (msg_i == M_SH_REQ) begin
          ov_o   = 1'b1;
          odst_o = site_oh;
          shr_o  = shr_i | site_oh;
        end else if (msg_i == M_EX_REQ) begin
          ov_o = 1'b1;
          if (others == '0) begin
            otyp_o = M_EX_REP;
            odst_o = site_oh;
            st_o   = D_WR;
            own_o  = site_i;
            shr_o  = '0;
          end else begin
            otyp_o = M_INV_REQ;
            odst_o = others;
            st_o   = D_TRD;
            shr_o  = others;
            pid_o  = site_i;
            pex_o  = 1'b1;
          end
        end
      end
      D_WR: begin
        if (msg_i == M_SH_REQ || msg_i == M_EX_REQ) begin
          ov_o   = 1'b1;
          otyp_o = (msg_i == M_EX_REQ) ? M_FLUSH_REQ : M_WB_REQ;
          odst_o = own_oh;
          st_o   = D_TWR;
          pid_o  = site_i;
          pex_o  = (msg_i == M_EX_REQ);
        end
      end
      D_TRD: begin
        if (msg_i == M_INV_REP && shr_i[site_i]) begin
          shr_o = rem;
          if (rem == '0) begin
            ov_o   = 1'b1;
            otyp_o = M_EX_REP;
            odst_o = pid_oh;
            st_o   = D_WR;
            own_o  = pid_i;
          end
        end
      end
      D_TWR: begin
        if (site_i == own_i &&
            ((msg_i == M_WB_REP && !pex_i) || (msg_i == M_FLUSH_REP && pex_i))) begin
          ov_o   = 1'b1;
          dat_o  = wdat_i;
          odat_o = wdat_i;
          odst_o = pid_oh;
          if (pex_i) begin
            otyp_o = M_EX_REP;
            st_o   = D_WR;
            own_o  = pid_i;
          end else begin
            otyp_o = M_SH_REP;
            st_o   = D_RD;
            shr_o  = own_oh | pid_oh;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_ctrl.sv
`timescale 1ns/1ps
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int K    = 4,
  parameter int NBLK = 4,
  parameter int DW   = 16,
  localparam int IW  = (K > 1) ? $clog2(K) : 1,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [3:0]    in_type_i,
  input  logic [IW-1:0] in_site_i,
  input  logic [BW-1:0] in_blk_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic [3:0]    out_type_o,
  output logic [K-1:0]  out_dst_o,
  output logic [BW-1:0] out_blk_o,
  output logic [DW-1:0] out_data_o
);
  dstate_e       st_q  [NBLK];
  logic [K-1:0]  shr_q [NBLK];
  logic [IW-1:0] own_q [NBLK];
  logic [IW-1:0] pid_q [NBLK];
  logic          pex_q [NBLK];
  logic [DW-1:0] dat_q [NBLK];

  logic [NBLK-1:0] pk_vld, pk_ex;
  logic [IW-1:0]   pk_site [NBLK];

  logic [NBLK-1:0] busy;
  logic            rp_hit, is_req, accept, park, proc_en;
  logic [BW-1:0]   rp_blk, proc_blk;
  msg_e            in_msg, proc_msg;
  logic [IW-1:0]   proc_site;

  dstate_e       n_st;
  logic [K-1:0]  n_shr, n_dst;
  logic [IW-1:0] n_own, n_pid;
  logic          n_pex, n_ov;
  logic [DW-1:0] n_dat, n_odat;
  msg_e          n_typ;

  always_comb begin
    for (int b = 0; b < NBLK; b++) busy[b] = (st_q[b] == D_TRD) || (st_q[b] == D_TWR);
    rp_hit = 1'b0;
    rp_blk = '0;
    for (int b = NBLK-1; b >= 0; b--) begin
      if (pk_vld[b] && !busy[b]) begin
        rp_hit = 1'b1;
        rp_blk = BW'(b);
      end
    end
    in_msg     = msg_e'(in_type_i);
    is_req     = (in_msg == M_SH_REQ) || (in_msg == M_EX_REQ);
    // replay owns the cycle; a full slot blocks its block
    in_ready_o = !rp_hit && !(is_req && busy[in_blk_i] && pk_vld[in_blk_i]);
    accept     = in_valid_i && in_ready_o;
    park       = accept && is_req && busy[in_blk_i];
    proc_en    = rp_hit || (accept && !park);
    proc_blk   = rp_hit ? rp_blk : in_blk_i;
    proc_msg   = rp_hit ? (pk_ex[rp_blk] ? M_EX_REQ : M_SH_REQ) : in_msg;
    proc_site  = rp_hit ? pk_site[rp_blk] : in_site_i;
  end

  dir_park_slots #(.NBLK(NBLK), .IW(IW), .BW(BW)) u_park (
    .clk_i, .rst_ni,
    .set_i(park), .set_blk_i(in_blk_i), .set_ex_i(in_msg == M_EX_REQ),
    .set_site_i(in_site_i),
    .clr_i(rp_hit), .clr_blk_i(rp_blk),
    .vld_o(pk_vld), .ex_o(pk_ex), .site_o(pk_site)
  );

  dir_next_state #(.K(K), .IW(IW), .DW(DW)) u_next (
    .st_i(st_q[proc_blk]), .shr_i(shr_q[proc_blk]), .own_i(own_q[proc_blk]),
    .pid_i(pid_q[proc_blk]), .pex_i(pex_q[proc_blk]), .dat_i(dat_q[proc_blk]),
    .msg_i(proc_msg), .site_i(proc_site), .wdat_i(in_data_i),
    .st_o(n_st), .shr_o(n_shr), .own_o(n_own), .pid_o(n_pid), .pex_o(n_pex),
    .dat_o(n_dat), .ov_o(n_ov), .otyp_o(n_typ), .odst_o(n_dst), .odat_o(n_odat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBLK; b++) begin
        st_q[b]  <= D_RD;
        shr_q[b] <= '0;
        own_q[b] <= '0;
        pid_q[b] <= '0;
        pex_q[b] <= 1'b0;
        dat_q[b] <= DW'(b);
      end
    end else if (proc_en) begin
      st_q[proc_blk]  <= n_st;
      shr_q[proc_blk] <= n_shr;
      own_q[proc_blk] <= n_own;
      pid_q[proc_blk] <= n_pid;
      pex_q[proc_blk] <= n_pex;
      dat_q[proc_blk] <= n_dat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_type_o  <= '0;
      out_dst_o   <= '0;
      out_blk_o   <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= proc_en && n_ov;
      if (proc_en && n_ov) begin
        out_type_o <= n_typ;
        out_dst_o  <= n_dst;
        out_blk_o  <= proc_blk;
        out_data_o <= n_odat;
      end
    end
  end

  AST_REPLY_ONE_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (out_type_o == M_SH_REP || out_type_o == M_EX_REP)) |-> $onehot(out_dst_o))
    else $error("reply mask"); // R10
  AST_OUT_HAS_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_dst_o != '0)) else $error("empty mask"); // R4
  AST_STALL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_req && busy[in_blk_i] && pk_vld[in_blk_i]) |-> !in_ready_o)
    else $error("full slot taken"); // R7
  AST_SH_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_msg == M_SH_REQ && st_q[in_blk_i] == D_RD)
    |=> (out_valid_o && out_type_o == M_SH_REP)) else $error("no shared reply"); // R2

  for (genvar b = 0; b < NBLK; b++) begin : g_chk
    AST_TR_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[b] == D_TRD) |-> (shr_q[b] != '0)) else $error("empty wait set"); // R4
    AST_OWNED_NO_SHR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[b] == D_WR) |-> (shr_q[b] == '0)) else $error("sharers while owned"); // R3
    AST_REPLAY_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pk_vld[b] && !busy[b]) |=> !pk_vld[b]) else $error("replay late"); // R8
  end
endmodule

// File: tb/sim_dir_ctrl.sv
`timescale 1ns/1ps
module sim_dir_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic        in_valid = 0, in_ready;
  logic [3:0]  in_type = 0;
  logic [1:0]  in_site = 0, in_blk = 0;
  logic [15:0] in_data = 0;
  logic        out_valid;
  logic [3:0]  out_type, out_dst;
  logic [1:0]  out_blk;
  logic [15:0] out_data;
  int total = 0, bad = 0;

  localparam logic [3:0] SHQ = 0, EXQ = 1, INVP = 2, WBP = 3, FLP = 4,
                         INVQ = 5, WBQ = 6, FLQ = 7, SHP = 8, EXP = 9;

  always #10 clk = ~clk;

  dir_ctrl #(.K(4), .NBLK(4), .DW(16)) u0 (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_type_i(in_type), .in_site_i(in_site), .in_blk_i(in_blk), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_type_o(out_type), .out_dst_o(out_dst),
    .out_blk_o(out_blk), .out_data_o(out_data));

  task automatic send(input logic [3:0] t, input logic [1:0] s, input logic [1:0] b,
                      input logic [15:0] d);
    @(negedge clk);
    in_valid = 1; in_type = t; in_site = s; in_blk = b; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic chk(input string req, input logic [3:0] t, input logic [3:0] d,
                     input logic [1:0] b, input logic [15:0] dat);
    total++;
    if (!out_valid || out_type !== t || out_dst !== d || out_blk !== b || out_data !== dat) begin
      bad++;
      $display("FAIL %s: got v=%0b t=%0d dst=%b blk=%0d dat=%h exp t=%0d dst=%b blk=%0d dat=%h",
               req, out_valid, out_type, out_dst, out_blk, out_data, t, d, b, dat);
    end
  endtask

  task automatic chk_ctl(input string req, input logic [3:0] t, input logic [3:0] d);
    total++;
    if (!out_valid || out_type !== t || out_dst !== d) begin
      bad++;
      $display("FAIL %s: got v=%0b t=%0d dst=%b exp t=%0d dst=%b",
               req, out_valid, out_type, out_dst, t, d);
    end
  endtask

  task automatic chk_none(input string req);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s: got out_valid=%0b exp 0", req, out_valid);
    end
  endtask

  task automatic t_reset;
    #1;
    total++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: got ready=%0b valid=%0b exp 1 0", in_ready, out_valid);
    end
  endtask

  task automatic t_clean_read;
    send(SHQ, 1, 0, 0); chk("R2 first reader", SHP, 4'b0010, 0, 16'd0);
    send(SHQ, 2, 0, 0); chk("R2 second reader", SHP, 4'b0100, 0, 16'd0);
  endtask

  task automatic t_upgrade_with_sharer;
    send(EXQ, 1, 0, 0); chk_ctl("R4 inv mask", INVQ, 4'b0100);
    send(INVP, 2, 0, 0); chk("R4 ex after ack", EXP, 4'b0010, 0, 16'd0);
  endtask

  task automatic t_ex_empty;
    send(EXQ, 3, 1, 0); chk("R3 empty set", EXP, 4'b1000, 1, 16'd1);
    send(SHQ, 0, 2, 0); chk("R1 reset data blk2", SHP, 4'b0001, 2, 16'd2);
    send(EXQ, 0, 2, 0); chk("R3 sole sharer", EXP, 4'b0001, 2, 16'd2);
  endtask

  task automatic t_writeback;
    send(SHQ, 3, 0, 0); chk_ctl("R5 wb req", WBQ, 4'b0010);
    send(WBP, 1, 0, 16'h0055); chk("R5 shared reply", SHP, 4'b1000, 0, 16'h0055);
    send(EXQ, 0, 0, 0); chk_ctl("R5 sharers owner+req", INVQ, 4'b1010);
    send(INVP, 1, 0, 0); chk_none("R4 partial ack silent");
    send(INVP, 3, 0, 0); chk("R4 last ack", EXP, 4'b0001, 0, 16'h0055);
  endtask

  task automatic t_flush;
    send(EXQ, 2, 1, 0); chk_ctl("R6 flush req", FLQ, 4'b1000);
    send(FLP, 3, 1, 16'h0077); chk("R6 ex reply", EXP, 4'b0100, 1, 16'h0077);
  endtask

  task automatic t_stall;
    send(SHQ, 0, 1, 0); chk_ctl("R5 wb to new owner", WBQ, 4'b0100);
    send(EXQ, 3, 1, 0); chk_none("R7 parked silent");
    @(negedge clk);
    in_valid = 1; in_type = SHQ; in_site = 1; in_blk = 1; #1;
    total++;
    if (in_ready !== 1'b0) begin bad++; $display("FAIL R7: got ready=%0b exp 0", in_ready); end
    @(negedge clk); #1;
    total++;
    if (in_ready !== 1'b0) begin bad++; $display("FAIL R7: got ready=%0b exp 0", in_ready); end
    in_valid = 0;
    send(SHQ, 1, 3, 0); chk("R7 other block served", SHP, 4'b0010, 3, 16'd3);
    send(WBP, 2, 1, 16'h0099); chk("R5 resolve", SHP, 4'b0001, 1, 16'h0099);
    @(posedge clk); #1;
    chk_ctl("R8 replay inv", INVQ, 4'b0101);
    send(INVP, 0, 1, 0); chk_none("R8 partial");
    send(INVP, 2, 1, 0); chk("R8 replay done", EXP, 4'b1000, 1, 16'h0099);
  endtask

  task automatic t_stray;
    send(INVP, 2, 3, 0); chk_none("R9 stray ack");
    send(WBP, 1, 3, 16'hdead); chk_none("R9 stray wb");
    send(SHQ, 0, 3, 0); chk("R9 data kept", SHP, 4'b0001, 3, 16'd3);
    send(EXQ, 2, 3, 0); chk_ctl("R9 set kept", INVQ, 4'b0011);
    send(INVP, 2, 3, 0); chk_none("R9 unlisted ack");
    send(INVP, 0, 3, 0); chk_none("R9 one left");
    send(INVP, 1, 3, 0); chk("R10 final reply", EXP, 4'b0100, 3, 16'd3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    t_reset;
    t_clean_read;
    t_upgrade_with_sharer;
    t_ex_empty;
    t_writeback;
    t_flush;
    t_stall;
    t_stray;
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule